// File: doc/BRIEF.md
# Sequential Prefetch Stream Buffer

This block sits next to a small direct-mapped cache and lowers its miss count by fetching ahead along sequential block addresses. Prefetched blocks never enter the cache. They wait in a set of small FIFOs, one per stream, and are looked at only when the cache misses. Data and instruction misses are treated the same way. All addresses are block addresses, so "the next block" is the address plus one.

When the cache misses, it raises a miss request. The block compares the miss address with the head entry of every stream that holds returned data. If a head matches, that block goes straight back to the cache and its FIFO slot is reused to prefetch the block after the stream's current tail. If no head matches, the block sends a demand read for the missed block. It then takes the stream that was allocated longest ago, restarts it at the next address, and fills it with one prefetch read per slot. Memory reads use a valid/ready request channel and a response channel that returns the request tag with the data.

Only one miss is handled at a time. A new miss is refused until every read issued for the previous miss has returned. The stream count and FIFO depth are parameters, and both must be powers of two.

Top module: `stream_prefetch_buf`

## Requirements
- R1: After reset `missReady` is 1, `fillValid` and `memReqValid` are 0, and every stream is empty, so the first miss after reset always reads memory.
- R2: A miss that matches no ready stream head issues a demand read for the miss address first. It then issues DEPTH prefetch reads at miss+1 up to miss+DEPTH. The cache receives the demand data with `fillFromStream` = 0.
- R3: Exactly one `fillValid` pulse occurs per accepted miss. Prefetched data never appears on the fill outputs.
- R4: A miss that matches the head of a stream whose head slot holds returned data is answered in the cycle after acceptance with the buffered data and `fillFromStream` = 1. No demand read is issued for it.
- R5: After a head hit, exactly one prefetch read is issued. Its address is the old head address plus DEPTH, which is the block after the stream's tail.
- R6: Only head entries are compared. A miss address held deeper in a stream is handled as in R2.
- R7: On each miss that matches no head, the streams are reallocated in rotating order starting from stream 0. The stream that is replaced is always the one allocated longest ago.
- R8: `missReady` goes low once a miss is accepted. It stays low until all reads for that miss have been issued and answered.
- R9: While `memReqValid` is 1 and `memReqReady` is 0, the request address and tag stay unchanged.
- R10: The request tag is {demand bit (MSB), stream index, slot index (LSBs)}. Memory returns the tag unchanged with the data. For the prefetches of a reallocated stream, the last prefetch carries slot DEPTH-1 and the index of the newly allocated stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| missValid | input | 1 | Cache miss request |
| missAddr | input | ADDR_W | Missed block address |
| missReady | output | 1 | Block can accept a miss |
| fillValid | output | 1 | Block returned to the cache |
| fillAddr | output | ADDR_W | Address of the returned block |
| fillData | output | DATA_W | Returned block data |
| fillFromStream | output | 1 | 1 when the block came from a stream buffer |
| memReqValid | output | 1 | Memory read request |
| memReqReady | input | 1 | Memory accepts the request |
| memReqAddr | output | ADDR_W | Read block address |
| memReqTag | output | 1+log2(NUM_STREAMS)+log2(DEPTH) | Request tag |
| memRespValid | input | 1 | Read data returned |
| memRespTag | input | 1+log2(NUM_STREAMS)+log2(DEPTH) | Tag of the returned read |
| memRespData | input | DATA_W | Returned data |

## Verification
The assertions assume that memory answers only reads it has accepted, returns each tag unchanged, and sends at most one response per cycle. They also assume that `missAddr` holds steady while `missValid` is high. The bench's memory model queues accepted requests and replays them in order after a fixed latency, echoing the tags. The driver raises a miss only after it has seen `missReady` high. Back-pressure comes from holding `memReqReady` low for a set number of cycles, never by dropping a request.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;

  typedef enum logic [1:0] {
    SLOT_EMPTY   = 2'd0,
    SLOT_PENDING = 2'd1,
    SLOT_READY   = 2'd2
  } slotState_e;

  typedef enum logic [1:0] {
    CT_IDLE     = 2'd0,
    CT_DEMAND   = 2'd1,
    CT_PREFETCH = 2'd2
  } ctrlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;   // miss taken this cycle
    logic popHit;   // head of selStream supplies the block
    logic alloc;    // selStream restarts at miss+1
  } sbufStrobe_t;

endpackage

// File: rtl/sbuf_datapath.sv
module sbuf_datapath
  import sbuf_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int NUM_STREAMS = 4,
  parameter int DEPTH       = 4,
  parameter int SW          = 2,
  parameter int DW          = 2,
  parameter int TAG_W       = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  sbufStrobe_t       strb,
  input  logic [SW-1:0]     selStream,
  input  logic [ADDR_W-1:0] missAddr,
  input  logic              memRespValid,
  input  logic [TAG_W-1:0]  memRespTag,
  input  logic [DATA_W-1:0] memRespData,
  output logic              hitAny,
  output logic [SW-1:0]     hitStream,
  output logic [DW-1:0]     hitSlot,
  output logic              fillValid,
  output logic [ADDR_W-1:0] fillAddr,
  output logic [DATA_W-1:0] fillData,
  output logic              fillFromStream
);

  logic              streamLive [NUM_STREAMS];
  logic [ADDR_W-1:0] headAddr   [NUM_STREAMS];
  logic [DW-1:0]     rdPtr      [NUM_STREAMS];
  slotState_e        slotSt     [NUM_STREAMS][DEPTH];
  logic [DATA_W-1:0] slotData   [NUM_STREAMS][DEPTH];
  logic [ADDR_W-1:0] latchAddr;

  logic [NUM_STREAMS-1:0] headHit;

  // one head comparator per stream
  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_cmp
    assign headHit[s] = streamLive[s]
                     && (slotSt[s][rdPtr[s]] == SLOT_READY)
                     && (headAddr[s] == missAddr);
  end

  // lowest index wins when two heads match
  always_comb begin
    hitAny    = 1'b0;
    hitStream = '0;
    for (int s = NUM_STREAMS - 1; s >= 0; s--) begin
      if (headHit[s]) begin
        hitAny    = 1'b1;
        hitStream = SW'(s);
      end
    end
  end

  assign hitSlot = rdPtr[hitStream];

  logic          respDemand;
  logic [SW-1:0] respStream;
  logic [DW-1:0] respSlot;

  assign respDemand = memRespTag[TAG_W-1];
  assign respStream = memRespTag[DW +: SW];
  assign respSlot   = memRespTag[DW-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_STREAMS; s++) begin
        streamLive[s] <= 1'b0;
        headAddr[s]   <= '0;
        rdPtr[s]      <= '0;
        for (int d = 0; d < DEPTH; d++) begin
          slotSt[s][d]   <= SLOT_EMPTY;
          slotData[s][d] <= '0;
        end
      end
      latchAddr      <= '0;
      fillValid      <= 1'b0;
      fillAddr       <= '0;
      fillData       <= '0;
      fillFromStream <= 1'b0;
    end else begin
      fillValid <= 1'b0;
      if (strb.accept) begin
        latchAddr <= missAddr;
      end
      if (strb.popHit) begin
        // head leaves, its slot becomes the new pending tail
        slotSt[selStream][rdPtr[selStream]] <= SLOT_PENDING;
        rdPtr[selStream]    <= rdPtr[selStream] + 1'b1;
        headAddr[selStream] <= headAddr[selStream] + ADDR_W'(1);
        fillValid      <= 1'b1;
        fillAddr       <= missAddr;
        fillData       <= slotData[selStream][rdPtr[selStream]];
        fillFromStream <= 1'b1;
      end
      if (strb.alloc) begin
        streamLive[selStream] <= 1'b1;
        headAddr[selStream]   <= missAddr + ADDR_W'(1);
        rdPtr[selStream]      <= '0;
        for (int d = 0; d < DEPTH; d++) begin
          slotSt[selStream][d] <= SLOT_PENDING;
        end
      end
      if (memRespValid) begin
        if (respDemand) begin
          fillValid      <= 1'b1;
          fillAddr       <= latchAddr;
          fillData       <= memRespData;
          fillFromStream <= 1'b0;
        end else begin
          slotSt[respStream][respSlot]   <= SLOT_READY;
          slotData[respStream][respSlot] <= memRespData;
        end
      end
    end
  end

  // R4: control pops only a ready head that matches the miss
  p_pop_ready_head_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.popHit |-> (slotSt[selStream][rdPtr[selStream]] == SLOT_READY
                     && headAddr[selStream] == missAddr));

  // R10: a prefetch response lands only in a slot waiting for it
  p_resp_to_pending_r10: assert property (@(posedge clk) disable iff (!rstN)
    (memRespValid && !respDemand) |-> (slotSt[respStream][respSlot] == SLOT_PENDING));

  // R3: fill is a single-cycle pulse
  p_fill_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    fillValid |=> !fillValid);

endmodule

// File: rtl/sbuf_ctrl.sv
module sbuf_ctrl
  import sbuf_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int NUM_STREAMS = 4,
  parameter int DEPTH       = 4,
  parameter int SW          = 2,
  parameter int DW          = 2,
  parameter int TAG_W       = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              missValid,
  input  logic [ADDR_W-1:0] missAddr,
  output logic              missReady,
  input  logic              hitAny,
  input  logic [SW-1:0]     hitStream,
  input  logic [DW-1:0]     hitSlot,
  output sbufStrobe_t       strb,
  output logic [SW-1:0]     selStream,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [TAG_W-1:0]  memReqTag,
  input  logic              memRespValid
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int OUT_W = $clog2(DEPTH + 2);

  ctrlState_e        ctSt;
  logic [ADDR_W-1:0] reqAddr;
  logic [SW-1:0]     reqStream;
  logic [DW-1:0]     reqSlot;
  logic [CNT_W-1:0]  remain;
  logic [OUT_W-1:0]  outstanding;
  logic [SW-1:0]     victimPtr;
  logic              accept;
  logic              reqFire;

  assign missReady = (ctSt == CT_IDLE) && (outstanding == '0);
  assign accept    = missValid && missReady;

  assign strb.accept = accept;
  assign strb.popHit = accept && hitAny;
  assign strb.alloc  = accept && !hitAny;
  assign selStream   = hitAny ? hitStream : victimPtr;

  assign memReqValid = (ctSt != CT_IDLE);
  assign memReqAddr  = reqAddr;
  assign memReqTag   = {(ctSt == CT_DEMAND), reqStream, reqSlot};
  assign reqFire     = memReqValid && memReqReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctSt        <= CT_IDLE;
      reqAddr     <= '0;
      reqStream   <= '0;
      reqSlot     <= '0;
      remain      <= '0;
      outstanding <= '0;
      victimPtr   <= '0;
    end else begin
      outstanding <= outstanding + OUT_W'(reqFire) - OUT_W'(memRespValid);
      case (ctSt)
        CT_IDLE: begin
          if (accept) begin
            if (hitAny) begin
              ctSt      <= CT_PREFETCH;
              reqAddr   <= missAddr + ADDR_W'(DEPTH);
              reqStream <= hitStream;
              reqSlot   <= hitSlot;
              remain    <= CNT_W'(1);
            end else begin
              ctSt      <= CT_DEMAND;
              reqAddr   <= missAddr;
              reqStream <= victimPtr;
              reqSlot   <= '0;
              remain    <= CNT_W'(DEPTH);
              victimPtr <= (victimPtr == SW'(NUM_STREAMS - 1)) ? '0 : victimPtr + 1'b1;
            end
          end
        end
        CT_DEMAND: begin
          if (reqFire) begin
            ctSt    <= CT_PREFETCH;
            reqAddr <= reqAddr + ADDR_W'(1);
          end
        end
        CT_PREFETCH: begin
          if (reqFire) begin
            reqAddr <= reqAddr + ADDR_W'(1);
            reqSlot <= reqSlot + 1'b1;
            remain  <= remain - 1'b1;
            if (remain == CNT_W'(1)) ctSt <= CT_IDLE;
          end
        end
        default: ctSt <= CT_IDLE;
      endcase
    end
  end

  // R8: a taken miss blocks the next one
  p_one_miss_r8: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> !missReady);

  // R8: memory answers only reads that were issued
  p_resp_expected_r8: assert property (@(posedge clk) disable iff (!rstN)
    memRespValid |-> (outstanding != '0 || reqFire));

  // R9: stalled request holds still
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=>
      (memReqValid && $stable(memReqAddr) && $stable(memReqTag)));

  // R4: a head hit sends no demand read
  p_hit_no_demand_r4: assert property (@(posedge clk) disable iff (!rstN)
    (accept && hitAny) |=> (memReqValid && !memReqTag[TAG_W-1]));

  // R2: a clean miss starts with the demand read of the miss address
  p_demand_first_r2: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !hitAny) |=>
      (memReqValid && memReqTag[TAG_W-1] && memReqAddr == $past(missAddr)));

endmodule

// File: rtl/stream_prefetch_buf.sv
module stream_prefetch_buf
  import sbuf_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int NUM_STREAMS = 4,
  parameter int DEPTH       = 4,
  localparam int SW         = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1,
  localparam int DW         = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int TAG_W      = 1 + SW + DW
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              missValid,
  input  logic [ADDR_W-1:0] missAddr,
  output logic              missReady,
  output logic              fillValid,
  output logic [ADDR_W-1:0] fillAddr,
  output logic [DATA_W-1:0] fillData,
  output logic              fillFromStream,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [TAG_W-1:0]  memReqTag,
  input  logic              memRespValid,
  input  logic [TAG_W-1:0]  memRespTag,
  input  logic [DATA_W-1:0] memRespData
);

  sbufStrobe_t   strb;
  logic [SW-1:0] selStream;
  logic          hitAny;
  logic [SW-1:0] hitStream;
  logic [DW-1:0] hitSlot;

  sbuf_ctrl #(
    .ADDR_W(ADDR_W), .NUM_STREAMS(NUM_STREAMS), .DEPTH(DEPTH),
    .SW(SW), .DW(DW), .TAG_W(TAG_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN),
    .missValid(missValid), .missAddr(missAddr), .missReady(missReady),
    .hitAny(hitAny), .hitStream(hitStream), .hitSlot(hitSlot),
    .strb(strb), .selStream(selStream),
    .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memReqAddr(memReqAddr), .memReqTag(memReqTag),
    .memRespValid(memRespValid)
  );

  sbuf_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_STREAMS(NUM_STREAMS), .DEPTH(DEPTH),
    .SW(SW), .DW(DW), .TAG_W(TAG_W)
  ) dp_i (
    .clk(clk), .rstN(rstN),
    .strb(strb), .selStream(selStream), .missAddr(missAddr),
    .memRespValid(memRespValid), .memRespTag(memRespTag), .memRespData(memRespData),
    .hitAny(hitAny), .hitStream(hitStream), .hitSlot(hitSlot),
    .fillValid(fillValid), .fillAddr(fillAddr), .fillData(fillData),
    .fillFromStream(fillFromStream)
  );

endmodule

// File: tb/stream_prefetch_buf_tb.sv
`timescale 1ns/1ps
module stream_prefetch_buf_tb_top;

  localparam int DEPTH = 4;
  localparam int NVEC  = 17;
  localparam int LAT   = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        missValid = 1'b0;
  logic [15:0] missAddr = '0;
  logic        missReady;
  logic        fillValid;
  logic [15:0] fillAddr;
  logic [31:0] fillData;
  logic        fillFromStream;
  logic        memReqValid;
  logic        memReqReady = 1'b0;
  logic [15:0] memReqAddr;
  logic [4:0]  memReqTag;
  logic        memRespValid = 1'b0;
  logic [4:0]  memRespTag = '0;
  logic [31:0] memRespData = '0;

  always #2.5 clk = ~clk;

  stream_prefetch_buf dut_i (
    .clk(clk), .rstN(rstN),
    .missValid(missValid), .missAddr(missAddr), .missReady(missReady),
    .fillValid(fillValid), .fillAddr(fillAddr), .fillData(fillData),
    .fillFromStream(fillFromStream),
    .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memReqAddr(memReqAddr), .memReqTag(memReqTag),
    .memRespValid(memRespValid), .memRespTag(memRespTag), .memRespData(memRespData)
  );

  // {expected stream hit, miss address}
  localparam logic [16:0] VEC [NVEC] = '{
    {1'b0, 16'h0100}, {1'b1, 16'h0101}, {1'b1, 16'h0102}, {1'b0, 16'h0200},
    {1'b1, 16'h0103}, {1'b1, 16'h0201}, {1'b0, 16'h0300}, {1'b0, 16'h0400},
    {1'b0, 16'h0500}, {1'b0, 16'h0104}, {1'b0, 16'h0202}, {1'b0, 16'h0301},
    {1'b0, 16'h0401}, {1'b1, 16'h0105}, {1'b0, 16'h0107}, {1'b1, 16'h0108},
    {1'b1, 16'h0402}
  };

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int missCount = 0;

  // observation state
  int          reqCount = 0;
  logic [15:0] firstAddr, lastAddr;
  logic [4:0]  firstTag, lastTag;
  int          fillCount = 0;
  logic [15:0] seenFillAddr;
  logic [31:0] seenFillData;
  logic        seenFromStream;
  int          fillCyc = 0;
  int          stallLeft = 0;

  // memory model queue
  logic [4:0]  qTag  [64];
  logic [15:0] qAddr [64];
  int          qDue  [64];
  int          qHead = 0;
  int          qTail = 0;

  function automatic logic [31:0] blkData(input logic [15:0] a);
    return {a ^ 16'hA5C3, ~a};
  endfunction

  function automatic string reqName(input int i, input bit h);
    if (i == 14) return "R6";
    if (i >= 8 && i <= 12) return "R7";
    return h ? "R4" : "R2";
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // memory: decides ready, logs requests that fire at the next edge, replays responses
  always @(negedge clk) begin
    if (stallLeft > 0) begin
      memReqReady = 1'b0;
      stallLeft   = stallLeft - 1;
    end else begin
      memReqReady = 1'b1;
    end
    if (memReqValid && memReqReady) begin
      if (reqCount == 0) begin
        firstAddr = memReqAddr;
        firstTag  = memReqTag;
      end
      lastAddr = memReqAddr;
      lastTag  = memReqTag;
      reqCount = reqCount + 1;
      qTag[qTail % 64]  = memReqTag;
      qAddr[qTail % 64] = memReqAddr;
      qDue[qTail % 64]  = cyc + LAT;
      qTail = qTail + 1;
    end
    if (qHead != qTail && qDue[qHead % 64] <= cyc) begin
      memRespValid = 1'b1;
      memRespTag   = qTag[qHead % 64];
      memRespData  = blkData(qAddr[qHead % 64]);
      qHead = qHead + 1;
    end else begin
      memRespValid = 1'b0;
    end
  end

  // fill monitor
  always @(negedge clk) begin
    if (rstN && fillValid) begin
      fillCount      = fillCount + 1;
      seenFillAddr   = fillAddr;
      seenFillData   = fillData;
      seenFromStream = fillFromStream;
      fillCyc        = cyc;
    end
  end

  task automatic doMiss(input logic [15:0] a, input bit expHit, input string rq, input int stall);
    int acceptCyc;
    @(negedge clk);
    while (!missReady) @(negedge clk);
    missAddr  = a;
    missValid = 1'b1;
    @(posedge clk);
    #1;
    missValid = 1'b0;
    acceptCyc = cyc;
    reqCount  = 0;
    fillCount = 0;
    stallLeft = stall;
    for (int k = 0; k < stall - 1; k++) begin
      @(negedge clk);
      chk("R8 busy during stall", {31'd0, missReady}, 32'd0);
      chk("R9 held request", {15'd0, memReqValid, memReqAddr}, {15'd0, 1'b1, a});
    end
    @(negedge clk);
    while (!missReady) @(negedge clk);
    chk({rq, " R3 one fill"}, fillCount, 1);
    chk({rq, " from stream"}, {31'd0, seenFromStream}, {31'd0, expHit});
    chk({rq, " fill addr"}, {16'd0, seenFillAddr}, {16'd0, a});
    chk({rq, " fill data"}, seenFillData, blkData(a));
    if (expHit) begin
      chk("R4 fill one cycle after accept", fillCyc, acceptCyc);
      chk("R5 one prefetch", reqCount, 1);
      chk("R5 prefetch past tail", {16'd0, firstAddr}, {16'd0, a + 16'(DEPTH)});
      chk("R4 no demand read", {31'd0, firstTag[4]}, 32'd0);
    end else begin
      chk({rq, " read count"}, reqCount, 1 + DEPTH);
      chk({rq, " demand addr"}, {16'd0, firstAddr}, {16'd0, a});
      chk({rq, " demand tag bit"}, {31'd0, firstTag[4]}, 32'd1);
      chk({rq, " last prefetch addr"}, {16'd0, lastAddr}, {16'd0, a + 16'(DEPTH)});
      chk("R10 R7 last prefetch tag", {27'd0, lastTag},
          {27'd0, 1'b0, 2'(missCount % 4), 2'(DEPTH - 1)});
      missCount++;
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL R8 watchdog: actual done=0 expected done=1");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 missReady after reset", {31'd0, missReady}, 32'd1);
    chk("R1 no fill after reset", {31'd0, fillValid}, 32'd0);
    chk("R1 no request after reset", {31'd0, memReqValid}, 32'd0);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      doMiss(VEC[i][15:0], VEC[i][16], reqName(i, VEC[i][16]), 0);
    end

    // back-pressure on the demand read of a fresh miss
    doMiss(16'h0700, 1'b0, "R2 stalled", 6);

    // reset while idle empties every stream
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    chk("R1 missReady in reset", {31'd0, missReady}, 32'd1);
    rstN = 1'b1;
    missCount = 0;
    doMiss(16'h0402, 1'b0, "R1 empty after reset", 0);
    doMiss(16'h0403, 1'b1, "R4", 0);

    finishRun();
  end

endmodule